// File: doc/BRIEF.md
# Five-Bit ROM Bank Controller

This block sits on a cartridge bus between a CPU and external ROM and RAM arrays. It decodes only the top three CPU address lines and sees only the five least significant data lines. CPU writes into the ROM address range do not reach the ROM. They load a small set of control registers instead. From those registers and the current address the block produces the upper ROM address lines and a chip select for the external RAM.

The controller holds four registers:
- a five-bit bank number for the switchable ROM window;
- a two-bit upper bank field, used for ROMs larger than 4 Mbit;
- a RAM enable flag;
- a mode flag.

A written bank number of zero, as the block sees it on its five data lines, becomes one. The block is not told the size of the ROM. A smaller ROM leaves the top bank outputs unconnected, so its banks simply wrap. A nonzero number that wraps onto bank zero in a small ROM is therefore not corrected.

Top module: `rom_bank_ctrl`

## Requirements
- R1: After a synchronous active-low reset the bank number is 1 and the upper field, mode flag and RAM enable are all 0. A read with `cpu_a_hi`=3'b010 then gives `rom_a_hi`=7'h01, `ram_bank`=0 and `ram_sel`=0.
- R2: A strobed write with `cpu_a_hi`=3'b001 and a nonzero `cpu_d_lo` stores that five-bit value as the bank number. This covers every address from $2000 to $3FFF, including $2100.
- R3: A strobed bank write of zero stores bank 1. A CPU value of 32 reaches the block as zero and so also selects 1.
- R4: A nonzero bank value whose low bits happen to address bank 0 of a small ROM (16 or 8) is stored as written, with no correction. For example, 16 gives `rom_a_hi[4:0]`=5'h10.
- R5: When `cpu_a_hi[1]`=1 (the switchable window $4000-$7FFF), `rom_a_hi` = {upper field, bank number}. The upper field is loaded from `cpu_d_lo[1:0]` by a strobed write with `cpu_a_hi`=3'b010.
- R6: When `cpu_a_hi[1]`=0 (the fixed window), `rom_a_hi` is 0 if the mode flag is 0, and {upper field, 5'b0} if the mode flag is 1.
- R7: `ram_bank` equals the upper field when the mode flag is 1 and 0 otherwise. The mode flag is loaded from `cpu_d_lo[0]` by a strobed write with `cpu_a_hi`=3'b011.
- R8: A strobed write with `cpu_a_hi`=3'b000 sets RAM enable when `cpu_d_lo[3:0]`=4'hA, regardless of `cpu_d_lo[4]`, and clears it for any other value.
- R9: `ram_sel` is 1 exactly when RAM enable is set and `cpu_a_hi`=3'b101.
- R10: Writes with `cpu_a_hi[2]`=1, and any cycle with `cpu_wr`=0, leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; registers load on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_a_hi | input | 3 | CPU address lines A15..A13 |
| cpu_d_lo | input | 5 | CPU data lines D4..D0 |
| cpu_wr | input | 1 | Write strobe, active high, sampled on clk |
| rom_a_hi | output | 7 | ROM address lines A20..A14 |
| ram_bank | output | 2 | External RAM bank lines |
| ram_sel | output | 1 | External RAM chip select, active high |

## Verification
Bank writes are tried with zero, with ordinary values, and with values such as 16 and 8. Together these separate the substitution rule from the wrap rule: a design that corrects any value mapping onto bank 0 fails on 16. Upper-field writes are combined with a zero bank write to show that substitution looks only at the five visible bits. Both mode settings are read in both ROM windows. Enable values that differ from 4'hA in a single bit, or only in D4, show that the decode uses exactly the low nibble. A long pseudo-random run then mixes all register writes, high-address writes and unstrobed cycles against the cycle model.

// File: rtl/rom_bank_pkg.sv
// Package: shared widths and the register-region encoding of the bank controller.
// Assumes the region is selected by address lines A14..A13 with A15 low.
package rom_bank_pkg;
    localparam int BANK_W  = 5;
    localparam int UPPER_W = 2;
    localparam int AHI_W   = 3;
    localparam int ROM_W   = BANK_W + UPPER_W;

    typedef enum logic [1:0] {
        RG_RAMEN = 2'b00,
        RG_BANK  = 2'b01,
        RG_UPPER = 2'b10,
        RG_MODE  = 2'b11
    } region_e;

    localparam int NUM_RG = 4;
endpackage

// File: rtl/rbc_write_decode.sv
// Module: turns a strobed CPU write in the lower half of the map into
// one load enable per control register.
// Assumes cpu_a_hi[AHI_W-1] is A15 and the two lines below it pick the region.
module rbc_write_decode
    import rom_bank_pkg::*;
#(
    parameter int A_W = AHI_W
) (
    input  logic [A_W-1:0]    a_hi,
    input  logic              wr,
    output logic [NUM_RG-1:0] load
);
    localparam int RG_LSB = A_W - 3;

    genvar g;
    generate
        for (g = 0; g < NUM_RG; g++) begin : g_rg
            // Purpose: raise load[g] when the write targets region g.
            always_comb begin
                load[g] = wr && !a_hi[A_W-1] && (a_hi[RG_LSB+1:RG_LSB] == 2'(g));
            end
        end
    endgenerate
endmodule

// File: rtl/rbc_bank_regs.sv
// Module: the four control registers, including the zero-to-one
// substitution on the bank number.
// Assumes only the data lines it is given are visible; wider CPU values
// have already been cut to D_W bits by the bus.
module rbc_bank_regs
    import rom_bank_pkg::*;
#(
    parameter int D_W  = BANK_W,
    parameter int UP_W = UPPER_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_RG-1:0] load,
    input  logic [D_W-1:0]    din,
    output logic [D_W-1:0]    bank_q,
    output logic [UP_W-1:0]   upper_q,
    output logic              mode_q,
    output logic              ram_en_q
);
    localparam logic [D_W-1:0] BANK_ONE = D_W'(1);
    localparam logic [3:0]     EN_KEY   = 4'hA;

    logic [D_W-1:0] bank_next;

    // Purpose: substitute bank 1 when the visible bits are all zero.
    always_comb begin
        bank_next = (din == '0) ? BANK_ONE : din;
    end

    // Purpose: load the register selected by the decoder, or reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q   <= BANK_ONE;
            upper_q  <= '0;
            mode_q   <= 1'b0;
            ram_en_q <= 1'b0;
        end else begin
            if (load[RG_RAMEN]) ram_en_q <= (din[3:0] == EN_KEY);
            if (load[RG_BANK])  bank_q   <= bank_next;
            if (load[RG_UPPER]) upper_q  <= din[UP_W-1:0];
            if (load[RG_MODE])  mode_q   <= din[0];
        end
    end
endmodule

// File: rtl/rbc_addr_map.sv
// Module: forms the ROM upper address lines, RAM bank lines and RAM select
// from the register state and the current CPU address.
// Assumes A14 separates the fixed window from the switchable one.
module rbc_addr_map
    import rom_bank_pkg::*;
#(
    parameter int A_W  = AHI_W,
    parameter int D_W  = BANK_W,
    parameter int UP_W = UPPER_W
) (
    input  logic [A_W-1:0]      a_hi,
    input  logic [D_W-1:0]      bank_q,
    input  logic [UP_W-1:0]     upper_q,
    input  logic                mode_q,
    input  logic                ram_en_q,
    output logic [D_W+UP_W-1:0] rom_a,
    output logic [UP_W-1:0]     ram_bank,
    output logic                ram_sel
);
    localparam logic [A_W-1:0] RAM_WIN = A_W'(3'b101) << (A_W - 3);
    localparam int             A14_BIT = A_W - 2;

    logic [UP_W-1:0] upper_eff;

    // Purpose: the upper field applies to the fixed window and RAM only in mode 1.
    always_comb begin
        upper_eff = mode_q ? upper_q : '0;
    end

    // Purpose: choose the ROM bank lines for the window being read.
    always_comb begin
        if (a_hi[A14_BIT]) rom_a = {upper_q, bank_q};
        else               rom_a = {upper_eff, {D_W{1'b0}}};
    end

    // Purpose: drive the RAM bank lines and the RAM chip select.
    always_comb begin
        ram_bank = upper_eff;
        ram_sel  = ram_en_q && (a_hi == RAM_WIN);
    end
endmodule

// File: rtl/rom_bank_ctrl.sv
// Module: top of the five-bit ROM bank controller. It ties the write
// decoder, the register set and the address map together.
// Assumes a single clock, with CPU writes sampled on its rising edge.
module rom_bank_ctrl
    import rom_bank_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AHI_W-1:0]   cpu_a_hi,
    input  logic [BANK_W-1:0]  cpu_d_lo,
    input  logic               cpu_wr,
    output logic [ROM_W-1:0]   rom_a_hi,
    output logic [UPPER_W-1:0] ram_bank,
    output logic               ram_sel
);
    logic [NUM_RG-1:0]  load;
    logic [BANK_W-1:0]  bank_q;
    logic [UPPER_W-1:0] upper_q;
    logic               mode_q;
    logic               ram_en_q;

    rbc_write_decode #(.A_W(AHI_W)) dec_i (
        .a_hi (cpu_a_hi),
        .wr   (cpu_wr),
        .load (load)
    );

    rbc_bank_regs #(.D_W(BANK_W), .UP_W(UPPER_W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .din      (cpu_d_lo),
        .bank_q   (bank_q),
        .upper_q  (upper_q),
        .mode_q   (mode_q),
        .ram_en_q (ram_en_q)
    );

    rbc_addr_map #(.A_W(AHI_W), .D_W(BANK_W), .UP_W(UPPER_W)) map_i (
        .a_hi     (cpu_a_hi),
        .bank_q   (bank_q),
        .upper_q  (upper_q),
        .mode_q   (mode_q),
        .ram_en_q (ram_en_q),
        .rom_a    (rom_a_hi),
        .ram_bank (ram_bank),
        .ram_sel  (ram_sel)
    );
endmodule

// File: rtl/rom_bank_ctrl_chk.sv
// Module: property checker for the bank controller, bound to the top module.
// Assumes the default widths of the package.
module rom_bank_ctrl_chk
    import rom_bank_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [AHI_W-1:0]   cpu_a_hi,
    input logic [BANK_W-1:0]  cpu_d_lo,
    input logic               cpu_wr,
    input logic [ROM_W-1:0]   rom_a_hi,
    input logic               ram_sel,
    input logic [NUM_RG-1:0]  load,
    input logic [BANK_W-1:0]  bank_q,
    input logic [UPPER_W-1:0] upper_q,
    input logic               mode_q,
    input logic               ram_en_q
);
    AST_BANK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_a_hi[1] |-> (rom_a_hi[BANK_W-1:0] != '0)) else $error("bank zero");   // R3

    AST_BANK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_a_hi == 3'b001 && cpu_d_lo != '0) |=> (bank_q == $past(cpu_d_lo))) else $error("bank load");   // R2

    AST_RAM_SEL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        ram_sel |-> (cpu_a_hi == 3'b101)) else $error("ram select window");   // R9

    AST_HIGH_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && cpu_a_hi[2]) |=> ($stable(bank_q) && $stable(upper_q) && $stable(mode_q) && $stable(ram_en_q))) else $error("high write changed state");   // R10

    AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load)) else $error("several loads");   // R10

    AST_SWITCH_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_a_hi[1] |-> (rom_a_hi[ROM_W-1:BANK_W] == upper_q)) else $error("upper field");   // R5
endmodule

bind rom_bank_ctrl rom_bank_ctrl_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_a_hi (cpu_a_hi),
    .cpu_d_lo (cpu_d_lo),
    .cpu_wr   (cpu_wr),
    .rom_a_hi (rom_a_hi),
    .ram_sel  (ram_sel),
    .load     (load),
    .bank_q   (bank_q),
    .upper_q  (upper_q),
    .mode_q   (mode_q),
    .ram_en_q (ram_en_q)
);

// File: tb/rom_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module rom_bank_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] a_hi = 3'b000;
    logic [4:0] d_lo = 5'd0;
    logic       wr = 1'b0;
    logic [6:0] rom_a;
    logic [1:0] rbank;
    logic       rsel;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // behavioural reference state
    int m_bank, m_up, m_mode, m_en;

    always #4 clk = ~clk;

    rom_bank_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_a_hi(a_hi), .cpu_d_lo(d_lo),
        .cpu_wr(wr), .rom_a_hi(rom_a), .ram_bank(rbank), .ram_sel(rsel)
    );

    // reference model update on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_bank = 1; m_up = 0; m_mode = 0; m_en = 0;
        end else if (wr && a_hi < 4) begin
            case (a_hi)
                0: m_en   = ((d_lo % 16) == 10) ? 1 : 0;
                1: m_bank = (d_lo == 0) ? 1 : d_lo;
                2: m_up   = d_lo % 4;
                default: m_mode = d_lo % 2;
            endcase
        end
    end

    task automatic compare(input string tag);
        int e_rom, e_rb, e_sel;
        if (a_hi[1]) e_rom = m_up * 32 + m_bank;
        else         e_rom = m_mode ? m_up * 32 : 0;
        e_rb  = m_mode ? m_up : 0;
        e_sel = (m_en == 1 && a_hi == 3'b101) ? 1 : 0;
        total++;
        if (int'(rom_a) != e_rom || int'(rbank) != e_rb || int'(rsel) != e_sel) begin
            bad++;
            $display("FAIL %s: rom=%0h bank=%0d sel=%0d expected rom=%0h bank=%0d sel=%0d",
                     tag, rom_a, rbank, rsel, e_rom, e_rb, e_sel);
        end
    endtask

    // drive one cycle at the falling edge, compare, then let the rising edge pass
    task automatic step(input logic [2:0] a, input logic [4:0] d, input logic w, input string tag);
        @(negedge clk);
        a_hi = a; d_lo = d; wr = w;
        #1 compare(tag);
    endtask

    // read cycle after a write, checking the resulting state
    task automatic rd(input logic [2:0] a, input string tag);
        step(a, 5'd0, 1'b0, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(3'b010, "R1 reset state switchable window");
        rd(3'b101, "R1 reset ram select off");
        step(3'b001, 5'd7, 1'b1, "R2 write bank 7");
        rd(3'b010, "R2 bank 7 readback");
        step(3'b001, 5'd31, 1'b1, "R2 write bank 31");
        rd(3'b011, "R2 bank 31 readback");
        step(3'b001, 5'd0, 1'b1, "R3 write zero");
        rd(3'b010, "R3 zero became one");
        step(3'b001, 5'(32), 1'b1, "R3 value 32 seen as zero");
        rd(3'b010, "R3 value 32 became one");
        step(3'b001, 5'd16, 1'b1, "R4 write 16");
        rd(3'b010, "R4 16 kept");
        step(3'b001, 5'd8, 1'b1, "R4 write 8");
        rd(3'b011, "R4 8 kept");
        step(3'b010, 5'd1, 1'b1, "R5 upper field 1");
        step(3'b001, 5'd0, 1'b1, "R5 zero with upper set");
        rd(3'b010, "R5 bank 0x21");
        rd(3'b000, "R6 fixed window mode 0");
        step(3'b011, 5'd1, 1'b1, "R7 mode set");
        rd(3'b000, "R6 fixed window mode 1");
        rd(3'b101, "R7 ram bank follows upper");
        step(3'b010, 5'd3, 1'b1, "R7 upper 3 in mode 1");
        rd(3'b001, "R7 ram bank 3");
        step(3'b011, 5'd2, 1'b1, "R7 mode cleared by bit0=0");
        rd(3'b000, "R7 mode 0 again");
        step(3'b000, 5'h1A, 1'b1, "R8 enable with D4 set");
        rd(3'b101, "R9 select in RAM window");
        rd(3'b100, "R9 no select outside window");
        rd(3'b111, "R9 no select at top");
        step(3'b000, 5'h0B, 1'b1, "R8 near key disables");
        rd(3'b101, "R8 disabled");
        step(3'b000, 5'h0A, 1'b1, "R8 enable key");
        step(3'b000, 5'h02, 1'b0, "R10 unstrobed write");
        rd(3'b101, "R10 enable survived unstrobed");
        step(3'b001, 5'd5, 1'b0, "R10 unstrobed bank");
        rd(3'b010, "R10 bank unchanged");
        step(3'b101, 5'd9, 1'b1, "R10 high write");
        step(3'b100, 5'd0, 1'b1, "R10 high write zero");
        rd(3'b010, "R10 bank after high writes");
        rd(3'b101, "R10 enable after high writes");
        for (int i = 0; i < 3000; i++) begin
            step(3'($urandom_range(0, 7)), 5'($urandom_range(0, 31)),
                 1'($urandom_range(0, 1)), "R5 mixed traffic");
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule